// File: doc/BRIEF.md
# Synchronous Character Hunt Receiver

This block is the receive front end for character-oriented synchronous links. It takes a serial bit stream qualified by a one-cycle bit strobe (a 1X clock enable) and, while hunting, slides a comparison window one bit at a time until the received bits equal a programmed synchronization character. In two-character mode it then demands that the second programmed character follows immediately. Alternatively, an active-low external sync input can place the character boundary directly, with no synchronization character on the line.

Once aligned, it cuts the stream into characters of 5 to 8 data bits, optionally followed by a parity bit. It compares only at character boundaries and delivers each character with a one-cycle strobe and a parity-error flag. Synchronization characters can be dropped from the delivered data. A sync-detect pulse is raised one bit time after a synchronization character is recognized. A hunt command abandons alignment at any moment. Configuration inputs are meant to change only while the receiver is hunting, apart from the strip enable.

Top module: `syn_hunt_rx`

## Requirements
- R1: The length code selects the character length: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8 data bits. Data arrives least significant bit first and is delivered right-aligned on char_o, with the unused upper bits zero.
- R2: In hunt state the receiver compares after every bit strobe. It synchronizes when the data bits of the most recent frame-length window equal the low bits of syn1_i. No character is delivered before synchronization.
- R3: With two_syn_i set, a syn1_i match must be followed directly by a character equal to syn2_i. If that character differs, the receiver returns to hunt without a sync pulse and delivers nothing.
- R4: With ext_en_i set, a bit strobe in hunt state with ext_sync_ni low ends hunting. The next received bit is bit 0 of the first character, and no sync pulse is produced.
- R5: sync_o is a one-cycle pulse issued with the first bit strobe after the one that completed a recognized synchronization character. This covers the final hunt match and any syn1_i character received while synchronized.
- R6: With strip_i set, a synchronized character equal to syn1_i, or to syn2_i in two-character mode, is not delivered; its sync pulse still occurs.
- R7: A nonzero parity mode appends one parity bit after the data bits of every frame. The mode codes are 0 none, 1 even, 2 odd, and 3 forced to force_val_i. par_err_o flags a mismatch together with the character and is low otherwise.
- R8: A hunt_i pulse returns the receiver to hunt, discards the partial character and any pending sync pulse, and no character follows until synchronization is regained.
- R9: char_valid_o pulses for one cycle after the clock edge that samples the last bit of a frame. After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | One-cycle strobe per received bit |
| rx_i | input | 1 | Serial data, sampled with bit_en_i |
| hunt_i | input | 1 | Hunt command |
| ext_en_i | input | 1 | Enable external sync framing |
| ext_sync_ni | input | 1 | External sync, active low |
| two_syn_i | input | 1 | Require two synchronization characters |
| strip_i | input | 1 | Drop synchronization characters |
| len_code_i | input | 2 | Character length code |
| par_mode_i | input | 2 | Parity mode code |
| force_val_i | input | 1 | Expected value in forced parity mode |
| syn1_i | input | 8 | First synchronization character |
| syn2_i | input | 8 | Second synchronization character |
| char_valid_o | output | 1 | Character strobe |
| char_o | output | 8 | Received character |
| par_err_o | output | 1 | Parity error for the strobed character |
| sync_o | output | 1 | Sync-detect pulse |

## Verification
The bench targets false alignment. Streams are built so that the pattern appears only at the intended bit, and a window offset by one would either sync early or deliver shifted characters. It sends a first character followed by a wrong second one in two-character mode; a design that stays half-synchronized would then deliver garbage. It checks the exact bit at which sync_o appears, which catches a pulse issued on the matching bit rather than one bit later. It checks parity with the bit flipped under every mode, and confirms that after a hunt command no character appears. A design that kept its alignment across the command would emit characters there.

// File: rtl/syn_hunt_rx_pkg.sv
package syn_hunt_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_SYN2 = 2'd1,
    ST_SYNC = 2'd2
  } rx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_FORCE = 2'd3
  } par_mode_e;
endpackage

// File: rtl/syn_hunt_rx_window.sv
module syn_hunt_rx_window
  import syn_hunt_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              rx_i,
  input  logic [CNT_W-1:0]  clen_i,
  input  logic [CNT_W-1:0]  flen_i,
  input  logic [1:0]        par_mode_i,
  input  logic              force_val_i,
  output logic [DATA_W-1:0] data_o,
  output logic              par_err_o
);
  localparam int HIST_W = DATA_W + 1;

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_nxt;
  logic              par_bit;
  logic              ones;

  // newest bit at index 0
  assign hist_nxt = {hist_q[HIST_W-2:0], rx_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hist_q <= '1;
    else if (bit_en_i) hist_q <= hist_nxt;
  end

  // oldest bit of the frame is data bit 0
  always_comb begin
    data_o = '0;
    for (int k = 0; k < DATA_W; k++) begin
      if (k < int'(clen_i)) data_o[k] = hist_nxt[int'(flen_i) - 1 - k];
    end
  end

  assign par_bit = hist_nxt[0];
  assign ones    = ^data_o;

  always_comb begin
    case (par_mode_e'(par_mode_i))
      PAR_EVEN:  par_err_o = ones ^ par_bit;
      PAR_ODD:   par_err_o = ~(ones ^ par_bit);
      PAR_FORCE: par_err_o = par_bit ^ force_val_i;
      default:   par_err_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/syn_hunt_rx_cmp.sv
module syn_hunt_rx_cmp #(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 4,
  parameter int NUM_PAT = 2
) (
  input  logic [DATA_W-1:0]              data_i,
  input  logic [CNT_W-1:0]               clen_i,
  input  logic [NUM_PAT-1:0][DATA_W-1:0] pat_i,
  output logic [NUM_PAT-1:0]             match_o
);
  logic [DATA_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int k = 0; k < DATA_W; k++) mask[k] = (k < int'(clen_i));
  end

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    assign match_o[p] = ((data_i ^ pat_i[p]) & mask) == '0;
  end
endmodule

// File: rtl/syn_hunt_rx_sync_out.sv
module syn_hunt_rx_sync_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic hunt_i,
  input  logic set_i,
  output logic sync_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      sync_o <= 1'b0;
    end else if (hunt_i) begin
      pend_q <= 1'b0;
      sync_o <= 1'b0;
    end else if (bit_en_i) begin
      sync_o <= pend_q;
      pend_q <= set_i;
    end else begin
      sync_o <= 1'b0;
    end
  end

  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o); // R5
  AST_SYNC_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(bit_en_i) && !$past(hunt_i)); // R5
endmodule

// File: rtl/syn_hunt_rx.sv
module syn_hunt_rx
  import syn_hunt_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5,
  parameter int LEN_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              rx_i,
  input  logic              hunt_i,
  input  logic              ext_en_i,
  input  logic              ext_sync_ni,
  input  logic              two_syn_i,
  input  logic              strip_i,
  input  logic [LEN_W-1:0]  len_code_i,
  input  logic [1:0]        par_mode_i,
  input  logic              force_val_i,
  input  logic [DATA_W-1:0] syn1_i,
  input  logic [DATA_W-1:0] syn2_i,
  output logic              char_valid_o,
  output logic [DATA_W-1:0] char_o,
  output logic              par_err_o,
  output logic              sync_o
);
  localparam int CNT_W   = $clog2(DATA_W + 2);
  localparam int NUM_PAT = 2;

  rx_state_e                      state_q, state_d;
  logic [CNT_W-1:0]               cnt_q, cnt_d;
  logic [CNT_W-1:0]               clen, flen;
  logic                           par_on;
  logic [DATA_W-1:0]              win_data;
  logic                           win_perr;
  logic [NUM_PAT-1:0][DATA_W-1:0] pats;
  logic [NUM_PAT-1:0]             match;
  logic                           last_bit;
  logic                           emit;
  logic                           detect;

  assign par_on  = par_mode_i != 2'd0;
  assign clen    = CNT_W'(MIN_W) + CNT_W'(len_code_i);
  assign flen    = clen + CNT_W'(par_on);
  assign pats[0] = syn1_i;
  assign pats[1] = syn2_i;

  syn_hunt_rx_window #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_window (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en_i),
    .rx_i        (rx_i),
    .clen_i      (clen),
    .flen_i      (flen),
    .par_mode_i  (par_mode_i),
    .force_val_i (force_val_i),
    .data_o      (win_data),
    .par_err_o   (win_perr)
  );

  syn_hunt_rx_cmp #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_PAT(NUM_PAT)) u_cmp (
    .data_i  (win_data),
    .clen_i  (clen),
    .pat_i   (pats),
    .match_o (match)
  );

  syn_hunt_rx_sync_out u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .hunt_i   (hunt_i),
    .set_i    (detect),
    .sync_o   (sync_o)
  );

  assign last_bit = cnt_q == (flen - 1'b1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    emit    = 1'b0;
    detect  = 1'b0;
    if (bit_en_i) begin
      case (state_q)
        ST_HUNT: begin
          // bit-wise search; external sync wins
          if (ext_en_i && !ext_sync_ni) begin
            state_d = ST_SYNC;
            cnt_d   = '0;
          end else if (match[0]) begin
            cnt_d = '0;
            if (two_syn_i) begin
              state_d = ST_SYN2;
            end else begin
              state_d = ST_SYNC;
              detect  = 1'b1;
            end
          end
        end
        ST_SYN2: begin
          if (last_bit) begin
            cnt_d = '0;
            if (match[1]) begin
              state_d = ST_SYNC;
              detect  = 1'b1;
            end else begin
              state_d = ST_HUNT;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_SYNC: begin
          if (last_bit) begin
            cnt_d  = '0;
            emit   = !(strip_i && (match[0] || (two_syn_i && match[1])));
            detect = match[0];
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          state_d = ST_HUNT;
          cnt_d   = '0;
        end
      endcase
    end
    if (hunt_i) begin
      state_d = ST_HUNT;
      cnt_d   = '0;
      emit    = 1'b0;
      detect  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_HUNT;
      cnt_q        <= '0;
      char_valid_o <= 1'b0;
      char_o       <= '0;
      par_err_o    <= 1'b0;
    end else begin
      state_q      <= state_d;
      cnt_q        <= cnt_d;
      char_valid_o <= emit;
      par_err_o    <= emit & win_perr;
      if (emit) char_o <= win_data;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |=> !char_valid_o); // R9
  AST_CHAR_ONLY_SYNCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |-> $past(state_q) == ST_SYNC); // R2
  AST_HUNT_DROPS_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_i |=> state_q == ST_HUNT && !char_valid_o && !sync_o); // R8
  AST_PERR_WITH_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> char_valid_o); // R7
  AST_CNT_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_HUNT |-> cnt_q < flen); // R1
endmodule

// File: tb/syn_hunt_rx_test.sv
module syn_hunt_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       rx = 1'b1;
  logic       hunt = 1'b0;
  logic       ext_en = 1'b0;
  logic       ext_n = 1'b1;
  logic       two_syn = 1'b0;
  logic       strip = 1'b0;
  logic [1:0] len_code = 2'd3;
  logic [1:0] par_mode = 2'd0;
  logic       force_val = 1'b0;
  logic [7:0] syn1 = 8'h32;
  logic [7:0] syn2 = 8'h32;
  logic       char_valid_o;
  logic [7:0] char_o;
  logic       par_err_o;
  logic       sync_o;

  int checks = 0;
  int fails = 0;
  int bits_sent = 0;
  bit done = 1'b0;

  logic [8:0] exp_q[$];
  string      exp_tag_q[$];
  int         sync_q[$];
  string      sync_tag_q[$];
  logic [8:0] got_e;
  int         got_s;
  string      got_t;

  always #5 clk = ~clk;

  syn_hunt_rx uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bit_en_i     (bit_en),
    .rx_i         (rx),
    .hunt_i       (hunt),
    .ext_en_i     (ext_en),
    .ext_sync_ni  (ext_n),
    .two_syn_i    (two_syn),
    .strip_i      (strip),
    .len_code_i   (len_code),
    .par_mode_i   (par_mode),
    .force_val_i  (force_val),
    .syn1_i       (syn1),
    .syn2_i       (syn2),
    .char_valid_o (char_valid_o),
    .char_o       (char_o),
    .par_err_o    (par_err_o),
    .sync_o       (sync_o)
  );

  task automatic send_bit(input logic b, input logic e_n);
    @(negedge clk);
    rx = b;
    ext_n = e_n;
    bit_en = 1'b1;
    @(posedge clk);
    bits_sent++;
    @(negedge clk);
    bit_en = 1'b0;
    ext_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input int len, input int pm,
                           input logic fv, input logic bad);
    logic [7:0] m;
    logic p;
    m = 8'hFF >> (8 - len);
    for (int k = 0; k < len; k++) send_bit(d[k], 1'b1);
    if (pm != 0) begin
      case (pm)
        1:       p = ^(d & m);
        2:       p = ~(^(d & m));
        default: p = fv;
      endcase
      send_bit(p ^ bad, 1'b1);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) send_bit(1'b1, 1'b1);
  endtask

  task automatic expect_char(input logic [7:0] d, input logic pe, input string tag);
    exp_q.push_back({pe, d});
    exp_tag_q.push_back(tag);
  endtask

  task automatic expect_sync(input string tag);
    sync_q.push_back(bits_sent + 1);
    sync_tag_q.push_back(tag);
  endtask

  task automatic hunt_cmd();
    @(negedge clk);
    hunt = 1'b1;
    @(negedge clk);
    hunt = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (char_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected char", {par_err_o, char_o}, 0);
        end else begin
          got_e = exp_q.pop_front();
          got_t = exp_tag_q.pop_front();
          check({par_err_o, char_o} === got_e, got_t, {par_err_o, char_o}, got_e);
        end
      end
      if (sync_o) begin
        if (sync_q.size() == 0) begin
          check(1'b0, "R3 unexpected sync pulse at bit", bits_sent, 0);
        end else begin
          got_s = sync_q.pop_front();
          got_t = sync_tag_q.pop_front();
          check(bits_sent == got_s, got_t, bits_sent, got_s);
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({char_valid_o, par_err_o, sync_o} == 3'b000, "R9 reset outputs",
          {char_valid_o, par_err_o, sync_o}, 0);
    check(char_o == 8'h00, "R9 reset char", char_o, 0);
    rst_n = 1'b1;
    idle(5);

    // R2 single SYN, 8 bits, no parity
    send_char(8'h32, 8, 0, 1'b0, 1'b0);
    expect_sync("R5 sync one bit after R2 match");
    expect_char(8'hA5, 1'b0, "R1 8-bit char A5");
    send_char(8'hA5, 8, 0, 1'b0, 1'b0);
    expect_char(8'h3C, 1'b0, "R1 8-bit char 3C");
    send_char(8'h3C, 8, 0, 1'b0, 1'b0);
    expect_char(8'h32, 1'b0, "R6 SYN kept without strip");
    send_char(8'h32, 8, 0, 1'b0, 1'b0);
    expect_sync("R5 sync on SYN while synced");

    // R6 strip
    strip = 1'b1;
    send_char(8'h32, 8, 0, 1'b0, 1'b0);
    expect_sync("R6 stripped SYN still pulses sync");
    expect_char(8'h81, 1'b0, "R6 data after stripped SYN");
    send_char(8'h81, 8, 0, 1'b0, 1'b0);
    strip = 1'b0;

    // R8 hunt command: nothing until resync
    hunt_cmd();
    send_char(8'h11, 8, 0, 1'b0, 1'b0);
    send_char(8'h22, 8, 0, 1'b0, 1'b0);
    check(exp_q.size() == 0 && sync_q.size() == 0, "R8 silent after hunt",
          exp_q.size(), 0);

    // R3 two SYN: failed second, then good pair
    two_syn = 1'b1;
    syn1 = 8'h16;
    syn2 = 8'h32;
    send_char(8'h16, 8, 0, 1'b0, 1'b0);
    send_char(8'h00, 8, 0, 1'b0, 1'b0);
    send_char(8'h16, 8, 0, 1'b0, 1'b0);
    send_char(8'h32, 8, 0, 1'b0, 1'b0);
    expect_sync("R3 sync after second SYN");
    expect_char(8'h5A, 1'b0, "R3 data after SYN pair");
    send_char(8'h5A, 8, 0, 1'b0, 1'b0);

    // R7 even parity, 5-bit
    hunt_cmd();
    two_syn = 1'b0;
    len_code = 2'd0;
    par_mode = 2'd1;
    syn1 = 8'h03;
    idle(4);
    send_char(8'h03, 5, 1, 1'b0, 1'b0);
    expect_sync("R5 sync 5-bit even");
    expect_char(8'h15, 1'b0, "R7 even good R1 5-bit");
    send_char(8'h15, 5, 1, 1'b0, 1'b0);
    expect_char(8'h06, 1'b1, "R7 even bad");
    send_char(8'h06, 5, 1, 1'b0, 1'b1);

    // R7 odd parity
    hunt_cmd();
    par_mode = 2'd2;
    idle(4);
    send_char(8'h03, 5, 2, 1'b0, 1'b0);
    expect_sync("R5 sync 5-bit odd");
    expect_char(8'h07, 1'b0, "R7 odd good");
    send_char(8'h07, 5, 2, 1'b0, 1'b0);
    expect_char(8'h1C, 1'b1, "R7 odd bad");
    send_char(8'h1C, 5, 2, 1'b0, 1'b1);

    // R4 external sync, 7-bit
    hunt_cmd();
    par_mode = 2'd0;
    len_code = 2'd2;
    ext_en = 1'b1;
    send_bit(1'b1, 1'b0);
    expect_char(8'h55, 1'b0, "R4 first char after ext sync R1 7-bit");
    send_char(8'h55, 7, 0, 1'b0, 1'b0);
    expect_char(8'h2A, 1'b0, "R4 second char after ext sync");
    send_char(8'h2A, 7, 0, 1'b0, 1'b0);

    // R7 forced parity, 6-bit
    hunt_cmd();
    len_code = 2'd1;
    par_mode = 2'd3;
    force_val = 1'b0;
    send_bit(1'b0, 1'b0);
    expect_char(8'h2D, 1'b0, "R7 forced good");
    send_char(8'h2D, 6, 3, 1'b0, 1'b0);
    expect_char(8'h12, 1'b1, "R7 forced bad");
    send_char(8'h12, 6, 3, 1'b0, 1'b1);

    hunt_cmd();
    ext_en = 1'b0;
    idle(12);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R1 all expected chars seen", exp_q.size(), 0);
    check(sync_q.size() == 0, "R5 all expected sync pulses seen", sync_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule